// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block is an asynchronous serial transmitter for a bus master that opens each message with an extended break. The host writes bytes through a one-entry holding buffer that feeds a shift register. On each baud tick from an external rate generator, the shift register moves the serial line to its next bit. A normal frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit.

The host can set a send-break control bit. If that bit is set when the shift register loads from the buffer, the byte is discarded and the shifter sends a break instead: thirteen low bit times (the start bit plus twelve forced-low bits) followed by a high stop bit. The hardware clears the control bit at the end of that stop bit. A message header therefore takes three steps: set the break bit, write any byte, then write the sync byte 0x55 once the first byte has moved into the shifter. The sync frame follows the break with no idle bit and no further host action.

Two flags report progress. One shows whether the holding buffer is empty and the other whether the shift register is idle. A one-clock pulse reports a write that was lost because the buffer was full. Dropping the transmit enable stops everything at once.

Top module: `uartx_brk_tx`

## Requirements
- R1: A normal frame is a low start bit, the eight data bits least significant bit first, then a high stop bit. Every bit lasts exactly one baud tick period, and a frame starts on the baud tick at which the shift register loads.
- R2: `tx` is high whenever the shift register is idle or `tx_enable` is low.
- R3: If `brk_flag` is 1 when the shift register loads, the frame is 13 low bit times followed by one high stop bit (14 bit times in all), and the written byte is discarded.
- R4: `brk_wr` loads `brk_wdata` into `brk_flag`. The hardware clears `brk_flag` on the baud tick that ends the stop bit of a break frame. The frame that loads on that same tick is a normal frame.
- R5: `brk_flag` is sampled only when the shift register loads. Setting or clearing it later does not change the frame already being sent.
- R6: A byte that is buffered while a frame is being sent loads on the tick that ends that frame's stop bit, so no idle bit appears between the two frames. This holds for a break followed by a sync byte.
- R7: `buf_empty` is 1 after reset. It goes to 0 the clock after a write is accepted and returns to 1 the clock after the buffer moves into the shift register.
- R8: `shift_empty` is 0 from the load of a frame until its last bit ends, for break frames and normal frames alike, and 1 otherwise.
- R9: A write while the buffer is full is dropped, and the buffered byte is kept. `overrun` is 1 for the one clock after that write.
- R10: Within one clock of `tx_enable` going low, the current frame is aborted, `tx` is high, and the buffer, the shift register and `brk_flag` are all cleared. Writes while `tx_enable` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable; low aborts and clears |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| brk_wr | input | 1 | Write strobe for the send-break bit |
| brk_wdata | input | 1 | Value written to the send-break bit |
| baud_tick | input | 1 | One-clock pulse per bit period |
| tx | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | Shift register is idle |
| brk_flag | output | 1 | Readback of the send-break bit |
| overrun | output | 1 | One-clock pulse on a dropped write |

## Verification
The hardest case to reach is the handover at the end of a break. On a single tick, the break's stop bit ends, the hardware clears the send-break bit, and the buffered sync byte loads. The sync byte must load as a normal frame and leave no idle bit. To set this up, the stimulus waits until the break frame has left the holding buffer and only then writes 0x55. It then samples 24 consecutive bit centres, checking that `shift_empty` stays low, that `brk_flag` falls between bit 13 and bit 14, and that the line returns to idle right afterwards. Separate cases write to the send-break bit in the middle of a frame, to show that it takes effect only when the shift register loads.

// File: rtl/uartx_pkg.sv
package uartx_pkg;

    localparam int DATA_W   = 8;
    localparam int BRK_LOW  = 12;
    localparam int SH_W     = BRK_LOW + 2;
    localparam int NORM_LEN = DATA_W + 2;
    localparam int CNT_W    = $clog2(SH_W + 1);

    typedef logic [SH_W-1:0]   frame_vec_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_BRK  = 1'b1
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;
        bitcnt_t     left;
        frame_vec_t  bits;
        logic        busy;
    } shift_state_t;

    localparam shift_state_t SHIFT_IDLE = '{kind: KIND_DATA, left: '0, bits: '1, busy: 1'b0};

    // Bit 0 of the vector is sent first.
    function automatic frame_vec_t build_frame(frame_kind_e k, byte_t d);
        frame_vec_t v;
        v = '1;
        if (k == KIND_BRK) begin
            v[BRK_LOW:0] = '0;
        end else begin
            v[0]        = 1'b0;
            v[DATA_W:1] = d;
        end
        return v;
    endfunction

    function automatic bitcnt_t frame_len(frame_kind_e k);
        return (k == KIND_BRK) ? bitcnt_t'(SH_W) : bitcnt_t'(NORM_LEN);
    endfunction

endpackage

// File: rtl/uartx_hold_buf.sv
module uartx_hold_buf
    import uartx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  take,
    output logic  full,
    output byte_t data,
    output logic  overrun
);

    logic  full_q;
    byte_t data_q;
    logic  ovr_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            full_q <= 1'b0;
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            ovr_q <= wr_en && full_q;
            if (wr_en && !full_q) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full    = full_q;
    assign data    = data_q;
    assign overrun = ovr_q;

    assert_take_from_full_R7: assert property (@(posedge clk) disable iff (rst)
        take |-> full_q);

    assert_drop_keeps_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (enable && wr_en && full_q) |=> $stable(data_q));

    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> $past(wr_en && full_q && enable));

endmodule

// File: rtl/uartx_brk_ctl.sv
module uartx_brk_ctl (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic brk_wr,
    input  logic brk_wdata,
    input  logic brk_done,
    output logic brk_q
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            flag_q <= 1'b0;
        end else if (brk_wr) begin
            flag_q <= brk_wdata;
        end else if (brk_done) begin
            flag_q <= 1'b0;
        end
    end

    assign brk_q = flag_q;

    assert_brk_autoclear_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && brk_done && !brk_wr) |=> !flag_q);

    assert_disable_clears_brk_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !flag_q);

endmodule

// File: rtl/uartx_shifter.sv
module uartx_shifter
    import uartx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  tick,
    input  logic  hold_full,
    input  byte_t hold_data,
    input  logic  brk_bit,
    output logic  take,
    output logic  brk_done,
    output logic  busy,
    output logic  tx
);

    shift_state_t st_q, st_d;
    logic         last;
    frame_kind_e  kind_n;

    always_comb begin
        st_d     = st_q;
        take     = 1'b0;
        brk_done = 1'b0;
        last     = st_q.busy && (st_q.left == bitcnt_t'(1));
        if (enable && tick && last && (st_q.kind == KIND_BRK)) begin
            brk_done = 1'b1;
        end
        // A bit being cleared on this tick does not apply to the next frame.
        kind_n = (brk_bit && !brk_done) ? KIND_BRK : KIND_DATA;
        if (enable && tick) begin
            if (hold_full && (!st_q.busy || last)) begin
                take      = 1'b1;
                st_d.kind = kind_n;
                st_d.bits = build_frame(kind_n, hold_data);
                st_d.left = frame_len(kind_n);
                st_d.busy = 1'b1;
            end else if (st_q.busy) begin
                if (last) begin
                    st_d = SHIFT_IDLE;
                end else begin
                    st_d.bits = {1'b1, st_q.bits[SH_W-1:1]};
                    st_d.left = st_q.left - bitcnt_t'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st_q <= SHIFT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign tx   = st_q.busy ? st_q.bits[0] : 1'b1;

    assert_break_bits_low_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.kind == KIND_BRK && st_q.left > bitcnt_t'(1)) |-> !tx);

    assert_bit_held_between_ticks_R1: assert property (@(posedge clk) disable iff (rst)
        (enable && st_q.busy && !tick) |=> (!enable || $stable(tx)));

    assert_count_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (st_q.left != '0 && st_q.left <= bitcnt_t'(SH_W)));

    assert_idle_after_disable_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (tx && !st_q.busy));

endmodule

// File: rtl/uartx_brk_tx.sv
module uartx_brk_tx
    import uartx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_enable,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        brk_wr,
    input  logic        brk_wdata,
    input  logic        baud_tick,
    output logic        tx,
    output logic        buf_empty,
    output logic        shift_empty,
    output logic        brk_flag,
    output logic        overrun
);

    logic  take;
    logic  full;
    byte_t hold_data;
    logic  brk_done;
    logic  brk_q;
    logic  busy;

    uartx_hold_buf u_hold (
        .clk     (clk),
        .rst     (rst),
        .enable  (tx_enable),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (full),
        .data    (hold_data),
        .overrun (overrun)
    );

    uartx_brk_ctl u_brk (
        .clk       (clk),
        .rst       (rst),
        .enable    (tx_enable),
        .brk_wr    (brk_wr),
        .brk_wdata (brk_wdata),
        .brk_done  (brk_done),
        .brk_q     (brk_q)
    );

    uartx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .enable    (tx_enable),
        .tick      (baud_tick),
        .hold_full (full),
        .hold_data (hold_data),
        .brk_bit   (brk_q),
        .take      (take),
        .brk_done  (brk_done),
        .busy      (busy),
        .tx        (tx)
    );

    assign buf_empty   = !full;
    assign shift_empty = !busy;
    assign brk_flag    = brk_q;

    assert_empty_line_high_R2: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> tx);

    assert_back_to_back_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_enable && baud_tick && brk_done && full) |=> !shift_empty);

endmodule

// File: tb/uartx_brk_tx_tb_top.sv
module uartx_brk_tx_tb_top;

    localparam int TICK_DIV = 8;
    localparam int WDOG     = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       tx_enable, wr_en, brk_wr, brk_wdata;
    logic [7:0] wr_data;
    logic       tx, buf_empty, shift_empty, brk_flag, overrun;
    int         phase = 0;
    logic       baud_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_q[$];
    int cyc = 0;

    always #4 clk = ~clk;

    always @(negedge clk) phase <= (phase == TICK_DIV - 1) ? 0 : phase + 1;
    assign baud_tick = (phase == 0);

    uartx_brk_tx dut_i (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .wr_en(wr_en), .wr_data(wr_data),
        .brk_wr(brk_wr), .brk_wdata(brk_wdata), .baud_tick(baud_tick), .tx(tx),
        .buf_empty(buf_empty), .shift_empty(shift_empty), .brk_flag(brk_flag),
        .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver side: expected bits into the scoreboard.
    task automatic push_frame(input logic [7:0] d, input bit brk);
        if (brk) begin
            for (int i = 0; i < 13; i++) exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
        end else begin
            exp_q.push_back(1'b0);
            for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
            exp_q.push_back(1'b1);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_brk(input bit v);
        @(negedge clk);
        brk_wr = 1'b1; brk_wdata = v;
        @(negedge clk);
        brk_wr = 1'b0;
    endtask

    task automatic wait_sample();
        do @(negedge clk); while (phase != TICK_DIV / 2);
    endtask

    task automatic wait_load();
        do @(negedge clk); while (shift_empty);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!shift_empty || !buf_empty);
        wait_sample();
    endtask

    // Monitor: compare the line at every bit centre while a frame is active.
    always @(negedge clk) begin
        if (!rst && phase == TICK_DIV / 2 && !shift_empty) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R3 unexpected bit", int'(tx), -1);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(tx == e, "R1/R3/R6 serial bit", int'(tx), int'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            check(1'b0, "watchdog", cyc, WDOG);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; tx_enable = 1'b0; wr_en = 1'b0; wr_data = '0;
        brk_wr = 1'b0; brk_wdata = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check(tx == 1'b1, "R2 reset tx", int'(tx), 1);
        check(buf_empty == 1'b1, "R7 reset buf_empty", int'(buf_empty), 1);
        check(shift_empty == 1'b1, "R8 reset shift_empty", int'(shift_empty), 1);
        check(brk_flag == 1'b0, "R4 reset brk_flag", int'(brk_flag), 0);
        check(overrun == 1'b0, "R9 reset overrun", int'(overrun), 0);
        tx_enable = 1'b1;

        // R1 / R7 / R8: one normal frame
        push_frame(8'hA5, 1'b0);
        write_byte(8'hA5);
        check(buf_empty == 1'b0, "R7 buf full after write", int'(buf_empty), 0);
        wait_load();
        check(buf_empty == 1'b1, "R7 buf empty after load", int'(buf_empty), 1);
        for (int i = 0; i < 10; i++) begin
            wait_sample();
            check(!shift_empty, "R8 busy during normal frame", int'(shift_empty), 0);
        end
        wait_sample();
        check(shift_empty && tx, "R2 R8 idle after frame", int'(tx), 1);
        check(exp_q.size() == 0, "R1 frame complete", exp_q.size(), 0);

        // R9 / R6: overrun and back-to-back data
        push_frame(8'h3C, 1'b0);
        push_frame(8'hC1, 1'b0);
        write_byte(8'h3C);
        wait_load();
        write_byte(8'hC1);
        write_byte(8'h77);
        check(overrun == 1'b1, "R9 overrun pulse", int'(overrun), 1);
        @(negedge clk);
        check(overrun == 1'b0, "R9 overrun one clock", int'(overrun), 0);
        wait_idle();
        check(exp_q.size() == 0, "R9 R6 dropped byte not sent", exp_q.size(), 0);

        // R3 / R4 / R6: header of break then sync
        write_brk(1'b1);
        check(brk_flag == 1'b1, "R4 brk_flag set by host", int'(brk_flag), 1);
        push_frame(8'hFF, 1'b1);
        push_frame(8'h55, 1'b0);
        write_byte(8'hFF);
        wait_load();
        write_byte(8'h55);
        for (int i = 0; i < 24; i++) begin
            wait_sample();
            check(!shift_empty, "R6 R8 no gap in header", int'(shift_empty), 0);
            if (i == 13) check(brk_flag == 1'b1, "R4 brk_flag held through stop bit", int'(brk_flag), 1);
            if (i == 14) check(brk_flag == 1'b0, "R4 brk_flag auto-cleared", int'(brk_flag), 0);
        end
        wait_sample();
        check(shift_empty && tx, "R6 header ends", int'(shift_empty), 1);
        check(exp_q.size() == 0, "R3 header bits all seen", exp_q.size(), 0);

        // R5: set break mid normal frame, clear mid break frame
        push_frame(8'h96, 1'b0);
        write_byte(8'h96);
        wait_load();
        repeat (3) wait_sample();
        write_brk(1'b1);
        wait_idle();
        check(brk_flag == 1'b1, "R5 brk_flag pending after normal frame", int'(brk_flag), 1);
        push_frame(8'h00, 1'b1);
        write_byte(8'h0F);
        wait_load();
        repeat (3) wait_sample();
        write_brk(1'b0);
        check(brk_flag == 1'b0, "R4 host clear", int'(brk_flag), 0);
        wait_idle();
        check(exp_q.size() == 0, "R5 frames kept their kind", exp_q.size(), 0);

        // R10: abort with frame, buffer and break bit active
        push_frame(8'h81, 1'b0);
        write_byte(8'h81);
        wait_load();
        write_byte(8'h42);
        write_brk(1'b1);
        wait_sample();
        @(negedge clk);
        tx_enable = 1'b0;
        exp_q.delete();
        @(negedge clk);
        check(tx == 1'b1, "R10 tx high on abort", int'(tx), 1);
        check(shift_empty == 1'b1, "R10 shifter cleared", int'(shift_empty), 1);
        check(buf_empty == 1'b1, "R10 buffer cleared", int'(buf_empty), 1);
        check(brk_flag == 1'b0, "R10 brk_flag cleared", int'(brk_flag), 0);
        write_byte(8'h00);
        check(buf_empty == 1'b1, "R10 write ignored when disabled", int'(buf_empty), 1);
        repeat (3) begin
            wait_sample();
            check(tx == 1'b1, "R2 line high while disabled", int'(tx), 1);
        end
        tx_enable = 1'b1;
        repeat (2) wait_sample();
        check(shift_empty && tx, "R10 nothing sent after re-enable", int'(tx), 1);

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule